// File: doc/BRIEF.md
# Memory-Mapped Countdown Timer with Level Interrupt

This block is one timer channel reached through an APB slave port with zero wait states. A counter of `CNT_W` bits steps down by one on every clock while it is enabled. Software places a start value in a load register and then sets the enable bit. The rising edge of the enable bit copies that start value into the counter. When the counter hits zero it records an expiry event. It then either wraps to all ones (free-running) or restarts from the load register (periodic). Elapsed time in free-running mode is the bitwise inverse of the current value.

An expiry sets a raw pending flag. A mask bit in the control register gates the pending flag onto the level interrupt output and the masked status registers, and it never stops the raw flag from being recorded. Software acknowledges an event by reading one of two clear-on-read locations, and writes to those locations do nothing. Clearing the enable bit freezes the counter and drops any pending event. Register offsets follow the fixed map that existing driver software expects.

Top module: `apb_down_timer`

## Requirements
- R1: After synchronous active-low reset, the load register, control register and counter are all zero, no event is pending, and `irq` is low.
- R2: `pready` is always 1 and `pslverr` is always 0. A write in the access phase updates the register at that clock edge. The load register sits at offset 0x00 and reads back in full. The control register sits at 0x08 with bit 0 = enable, bit 1 = periodic mode, bit 2 = interrupt mask, and its upper bits read as zero.
- R3: On the first clock edge at which the registered enable is 1 and was 0 at the previous edge, the counter takes the load value. While enable is 0, the counter holds its value.
- R4: While enabled and past the loading edge, a counter that is not zero decreases by one per clock. Its value reads at offset 0x04.
- R5: In free-running mode (bit 1 = 0), a counter that is at zero while running becomes all ones at the next edge.
- R6: In periodic mode (bit 1 = 1), a counter that is at zero while running reloads the load value at the next edge, which gives a period of load+1 cycles.
- R7: A running counter at zero sets the raw pending flag at the next edge. The raw flag reads at 0xA8 bit 0. `irq`, masked status (0x10 bit 0) and combined status (0xA0 bit 0) all equal raw AND NOT mask.
- R8: A read of 0x0C or 0xA4 returns zero and clears the pending flag at that edge. Writes to these offsets leave the flag unchanged.
- R9: While enable is 0, the pending flag is cleared at each edge.
- R10: If an expiry and a clearing read fall on the same edge, the flag ends up set.
- R11: Offset 0xAC reads the `VERSION` parameter. Every unmapped offset reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Level interrupt, raw pending AND NOT mask |

## Verification
The bench targets a load of zero in periodic mode, which expires on every cycle. In that state a clearing read lands on an expiry edge, so a design that gives the clear priority would drop the flag (R10). It also checks the wrap in free-running mode, where a design that reloads instead of wrapping would show a small count rather than one near all ones. Toggling enable is checked too: a design that fails to reload on the enable edge would continue from a stale count, and one that keeps the flag while disabled would leave `irq` high. Writes to the clearing and unmapped offsets, together with mask changes, are checked against the raw and masked status, so that a mask which blocks the raw flag, or an acknowledge triggered by writes, shows up at the ports.

// File: rtl/timer_pkg.sv
// timer_pkg: register offsets and the control-field type shared by the
// countdown timer modules. Assumes a byte-addressed 8-bit offset space.
package timer_pkg;
    localparam logic [7:0] OFS_LOAD     = 8'h00;
    localparam logic [7:0] OFS_CUR      = 8'h04;
    localparam logic [7:0] OFS_CTRL     = 8'h08;
    localparam logic [7:0] OFS_ACK      = 8'h0C;
    localparam logic [7:0] OFS_MSTAT    = 8'h10;
    localparam logic [7:0] OFS_SYS_MST  = 8'hA0;
    localparam logic [7:0] OFS_SYS_ACK  = 8'hA4;
    localparam logic [7:0] OFS_SYS_RAW  = 8'hA8;
    localparam logic [7:0] OFS_VER      = 8'hAC;

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic mask;      // bit 2
        logic periodic;  // bit 1
        logic run;       // bit 0
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
// tmr_counter: down counter with load-on-enable-edge and two reload modes.
// Assumes the control and load inputs are registered by the caller.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic run_q;
    logic at_zero;

    assign at_zero = (cnt == '0);
    assign expire  = run && run_q && at_zero;

    // Remember last enable value to detect the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Load, decrement, wrap or reload the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !run_q) begin
            cnt <= load_val;
        end else if (run) begin
            if (at_zero) cnt <= periodic ? load_val : ALL_ONES;
            else         cnt <= cnt - 1'b1;
        end
    end

    // R3
    load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !run_q) |=> (cnt == $past(load_val)));
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R5
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && cnt == '0 && !periodic) |=> (cnt == ALL_ONES));
    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && cnt == '0 && periodic) |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tmr_irq.sv
// tmr_irq: raw pending flag with set-over-clear priority and a masked level
// output. Assumes 'expire' is a one-cycle-per-event qualifier from the counter.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic expire,
    input  logic ack,
    input  logic mask,
    output logic raw,
    output logic irq
);
    // Track pending event: disable clears, expiry sets, acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw <= 1'b0;
        else if (!run)   raw <= 1'b0;
        else if (expire) raw <= 1'b1;
        else if (ack)    raw <= 1'b0;
    end

    assign irq = raw & ~mask;

    // R7
    expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);
    // R9
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !raw);
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> !raw);
    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && expire && run) |=> raw);
endmodule

// File: rtl/tmr_apb_regs.sv
// tmr_apb_regs: zero-wait APB register file and read mux for one timer.
// Assumes single-channel system registers and a fixed version constant.
module tmr_apb_regs
    import timer_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h3230_3141
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    input  logic              irq,
    output logic [CNT_W-1:0]  load_val,
    output tmr_ctrl_t         ctrl,
    output logic              ack,
    output logic [DATA_W-1:0] prdata
);
    logic       acc, wr, rd;
    logic [7:0] ofs;

    assign acc = psel && penable;
    assign wr  = acc && pwrite;
    assign rd  = acc && !pwrite;
    assign ofs = 8'(paddr);
    assign ack = rd && (ofs == OFS_ACK || ofs == OFS_SYS_ACK);

    // Capture the load register on access-phase writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      load_val <= '0;
        else if (wr && ofs == OFS_LOAD)  load_val <= CNT_W'(pwdata);
    end

    // Capture the control register on access-phase writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl <= '0;
        else if (wr && ofs == OFS_CTRL)  ctrl <= tmr_ctrl_t'(pwdata[CTRL_W-1:0]);
    end

    // Select read data by offset; unmapped and clear-on-read offsets give 0.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (ofs)
                OFS_LOAD:    prdata = DATA_W'(load_val);
                OFS_CUR:     prdata = DATA_W'(cnt);
                OFS_CTRL:    prdata = DATA_W'(ctrl);
                OFS_MSTAT:   prdata = DATA_W'(irq);
                OFS_SYS_MST: prdata = DATA_W'(irq);
                OFS_SYS_RAW: prdata = DATA_W'(raw);
                OFS_VER:     prdata = DATA_W'(VERSION);
                default:     prdata = '0;
            endcase
        end
    end

    // R11
    stray_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ofs != OFS_LOAD) |=> $stable(load_val));
    // R11
    stray_write_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ofs != OFS_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/apb_down_timer.sv
// apb_down_timer: single-channel countdown timer with an APB slave port and a
// level interrupt. Assumes one clock domain and CNT_W <= DATA_W.
module apb_down_timer
    import timer_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h3230_3141
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             ack;
    logic             raw;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tmr_apb_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VERSION(VERSION)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .cnt(cnt),
        .raw(raw), .irq(irq), .load_val(load_val), .ctrl(ctrl),
        .ack(ack), .prdata(prdata)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .periodic(ctrl.periodic),
        .load_val(load_val), .cnt(cnt), .expire(expire)
    );

    tmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .expire(expire),
        .ack(ack), .mask(ctrl.mask), .raw(raw), .irq(irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt == '0));
endmodule

// File: tb/tb_apb_down_timer.sv
module tb_apb_down_timer;
    localparam logic [31:0] VER = 32'h3230_3141;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    apb_down_timer dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    always #5 clk = ~clk;

    // Reference model built from the requirements.
    logic [31:0] m_load, m_cnt;
    logic [2:0]  m_ctrl;
    logic        m_runq, m_raw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_load <= '0; m_cnt <= '0; m_ctrl <= '0; m_runq <= 1'b0; m_raw <= 1'b0;
        end else begin
            logic acc, rd, clr, exp_now;
            acc = psel && penable;
            rd  = acc && !pwrite;
            clr = rd && (paddr == 8'h0C || paddr == 8'hA4);
            exp_now = m_ctrl[0] && m_runq && (m_cnt == 0);
            if (acc && pwrite && paddr == 8'h00) m_load <= pwdata;
            if (acc && pwrite && paddr == 8'h08) m_ctrl <= pwdata[2:0];
            m_runq <= m_ctrl[0];
            if (m_ctrl[0] && !m_runq)  m_cnt <= m_load;
            else if (m_ctrl[0])        m_cnt <= (m_cnt == 0) ? (m_ctrl[1] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
            if (!m_ctrl[0])    m_raw <= 1'b0;
            else if (exp_now)  m_raw <= 1'b1;
            else if (clr)      m_raw <= 1'b0;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_load;
            8'h04: return m_cnt;
            8'h08: return {29'd0, m_ctrl};
            8'h10, 8'hA0: return {31'd0, m_raw & ~m_ctrl[2]};
            8'hA8: return {31'd0, m_raw};
            8'hAC: return VER;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h08: return "R2";
            8'h04: return "R4";
            8'h10, 8'hA0, 8'hA8: return "R7";
            8'h0C, 8'hA4: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        #1 check("R2", {30'd0, pslverr, pready}, 32'd1);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string tag);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        #1 check(tag, prdata, exp_read(a));
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 check("R7", {31'd0, irq}, {31'd0, m_raw & ~m_ctrl[2]});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    logic [7:0] addrs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'hA0,
                               8'hA4, 8'hA8, 8'hAC, 8'h14, 8'h9C, 8'hFC};

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1 check("R1", {31'd0, irq}, 32'd0);
        apb_rd(8'h00, "R1"); apb_rd(8'h04, "R1"); apb_rd(8'h08, "R1"); apb_rd(8'hA8, "R1");
        // R11 version and unmapped offsets
        apb_rd(8'hAC, "R11"); apb_rd(8'h14, "R11");
        apb_wr(8'h14, 32'hDEAD_BEEF); apb_rd(8'h00, "R11"); apb_rd(8'h08, "R11");
        // R2 readback with upper control bits dropped
        apb_wr(8'h00, 32'h1234_5678); apb_rd(8'h00, "R2");
        apb_wr(8'h08, 32'hFFFF_FFF8); apb_rd(8'h08, "R2");
        // R3 R4 start from load, count down
        apb_wr(8'h00, 32'd20); apb_wr(8'h08, 32'h1);
        apb_rd(8'h04, "R3"); apb_rd(8'h04, "R4");
        // R5 free-running wrap near all ones, R7 raw set
        idle(25); apb_rd(8'h04, "R5"); apb_rd(8'hA8, "R7");
        check("R5", {31'd0, m_cnt[31]}, 32'd1);
        // R8 writes to clear offsets do nothing, reads clear
        apb_wr(8'h0C, 32'h1); apb_wr(8'hA4, 32'h1); apb_rd(8'hA8, "R8");
        apb_rd(8'h0C, "R8"); apb_rd(8'hA8, "R8");
        // R7 mask keeps raw but drops irq and masked status
        apb_wr(8'h08, 32'h0); apb_wr(8'h00, 32'd3); apb_wr(8'h08, 32'h7);
        idle(12); apb_rd(8'hA8, "R7"); apb_rd(8'h10, "R7"); apb_rd(8'hA0, "R7");
        // R9 disabling clears pending, R3 count holds
        apb_wr(8'h08, 32'h2); idle(2);
        apb_rd(8'hA8, "R9"); apb_rd(8'h04, "R3"); idle(5); apb_rd(8'h04, "R3");
        // R6 periodic reload, R10 set wins over clear with load zero
        apb_wr(8'h00, 32'd6); apb_wr(8'h08, 32'h3); idle(17); apb_rd(8'h04, "R6");
        apb_wr(8'h08, 32'h2); apb_wr(8'h00, 32'd0); apb_wr(8'h08, 32'h3); idle(3);
        apb_rd(8'hA4, "R10"); apb_rd(8'hA8, "R10");
        check("R10", {31'd0, m_raw}, 32'd1);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 9);
            if (op == 0)      apb_wr(8'h00, ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 40)));
            else if (op == 1) apb_wr(8'h08, 32'($urandom_range(0, 7)));
            else if (op == 2) apb_wr(addrs[$urandom_range(0, 11)], $urandom);
            else if (op < 7)  begin
                logic [7:0] a = addrs[$urandom_range(0, 11)];
                apb_rd(a, tag_of(a));
            end
            else idle($urandom_range(0, 30));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule